// File: doc/BRIEF.md
# Dual-Rail Completion-Detecting Ripple Adder

The block adds two WIDTH-bit operands with a ripple carry chain. Each carry travels on a pair of rails, so the adder can tell when every carry has settled. Operand bit positions whose two bits are equal settle their carry-out straight away. Positions whose bits differ wait for the carry below them. The done flag therefore rises after a number of cycles set by the longest stretch of differing bits, not after a fixed worst case of WIDTH cycles.

The model is synchronous. Each clock edge moves a settled carry up by one bit position. Lowering start returns every rail pair to the empty state, which plays the role of a precharge. The sum bits are plain single-rail logic computed from the settled carries.

start and done are plain control pins and have no back-pressure. The user raises start with the operands already applied, holds start and the operands steady until done is seen, then lowers start before presenting the next operation.

Top module: `dr_selftimed_adder`

## Requirements
- R1: Each carry is a rail pair coded as 00 = empty, 01 = carry 0, 10 = carry 1; the pair 11 never occurs.
- R2: At any clock edge that samples start low, every rail pair returns to empty, and done is low after reset.
- R3: Once a rail pair has settled, it keeps its value until an edge that samples start low.
- R4: A position with both operand bits 0 settles its carry-out to 01 at the first edge that samples start high.
- R5: A position with both operand bits 1 settles its carry-out to 10 at the first edge that samples start high.
- R6: A position whose operand bits differ copies the rail pair of its carry-in one edge after that carry-in settles. The carry-in of bit 0 is the parameter CARRY_IN, and it settles at the first edge that samples start high.
- R7: done is high exactly when start is high and all rail pairs are settled. It therefore first rises after 1 + L edges with start high, where L is the longest run of adjacent positions whose operand bits differ.
- R8: While done is high, {carry_out, sum} equals op_a + op_b + CARRY_IN.
- R9: done is low in every cycle in which start is low.
- R10: While start stays high after done, sum, carry_out and done hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | High to evaluate; low empties the rails |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Sum bits, valid while done is high |
| carry_out | output | 1 | Carry out of the top bit, valid while done is high |
| done | output | 1 | Completion flag |

## Verification
The assertions check on every cycle that no rail pair reaches 11 and that an edge sampling start low empties the rails. They also check that settled pairs hold, that equal-bit positions settle at once, and that a high done always comes with a correct sum. Only the bench scenarios can show that the latency equals one plus the longest run of differing bits. The same holds for the boundaries: full-width propagation, no propagation, and a run that begins at bit 0. The bench also shows that done falls as soon as start is lowered.

// File: rtl/dr_add_pkg.sv
package dr_add_pkg;
  typedef enum logic [1:0] {
    RAIL_EMPTY = 2'b00,
    RAIL_ZERO  = 2'b01,
    RAIL_ONE   = 2'b10,
    RAIL_BAD   = 2'b11
  } rail_t;
endpackage

// File: rtl/dr_carry_seed.sv
module dr_carry_seed
  import dr_add_pkg::*;
#(
  parameter bit CARRY_IN = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output rail_t seed_rail
);
  localparam rail_t SEED_VAL = CARRY_IN ? RAIL_ONE : RAIL_ZERO;

  always_ff @(posedge clk) begin
    if (!rst_n || !start) seed_rail <= RAIL_EMPTY;
    else                  seed_rail <= SEED_VAL;
  end

  // R6: carry-in of bit 0 settles at the first evaluating edge
  a_r6_seed_settles: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (seed_rail == SEED_VAL));
endmodule

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
  import dr_add_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  a_bit,
  input  logic  b_bit,
  input  rail_t cin_rail,
  output rail_t cout_rail
);
  logic kill_bit, gen_bit;
  assign kill_bit = ~a_bit & ~b_bit;
  assign gen_bit  =  a_bit &  b_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || !start) begin
      cout_rail <= RAIL_EMPTY;
    end else if (cout_rail == RAIL_EMPTY) begin
      if (kill_bit)     cout_rail <= RAIL_ZERO;
      else if (gen_bit) cout_rail <= RAIL_ONE;
      else              cout_rail <= cin_rail;
    end
  end

  a_r1_no_illegal_pair: assert property (@(posedge clk) disable iff (!rst_n)
    cout_rail != RAIL_BAD);
  a_r2_empty_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cout_rail == RAIL_EMPTY));
  a_r3_settled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cout_rail != RAIL_EMPTY) |=> $stable(cout_rail));
  a_r4_kill_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (start && kill_bit) |=> (cout_rail == RAIL_ZERO));
  a_r5_gen_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (start && gen_bit) |=> (cout_rail == RAIL_ONE));
  a_r6_propagate_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (a_bit ^ b_bit) && cin_rail != RAIL_EMPTY) |=> (cout_rail == $past(cin_rail)));
endmodule

// File: rtl/dr_completion.sv
module dr_completion
  import dr_add_pkg::*;
#(
  parameter int PAIRS = 17
) (
  input  logic              start,
  input  rail_t [PAIRS-1:0] rails,
  output logic              all_done
);
  logic [PAIRS-1:0] settled;

  for (genvar i = 0; i < PAIRS; i++) begin : g_settle
    assign settled[i] = rails[i][1] | rails[i][0];
  end

  assign all_done = start & (&settled);
endmodule

// File: rtl/dr_sum_stage.sv
module dr_sum_stage
  import dr_add_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  rail_t [WIDTH:0]  carry,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum[i] = op_a[i] ^ op_b[i] ^ carry[i][1];
  end
  assign carry_out = carry[WIDTH][1];
endmodule

// File: rtl/dr_selftimed_adder.sv
module dr_selftimed_adder
  import dr_add_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter bit CARRY_IN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);
  localparam int PAIRS = WIDTH + 1;

  rail_t [WIDTH:0] carry;

  dr_carry_seed #(.CARRY_IN(CARRY_IN)) u_seed (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_rail(carry[0])
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    dr_carry_cell u_cell (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_bit(op_a[i]), .b_bit(op_b[i]),
      .cin_rail(carry[i]), .cout_rail(carry[i+1])
    );
  end

  dr_completion #(.PAIRS(PAIRS)) u_done (
    .start(start), .rails(carry), .all_done(done)
  );

  dr_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .op_a(op_a), .op_b(op_b), .carry(carry), .sum(sum), .carry_out(carry_out)
  );

  a_r8_sum_correct: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + PAIRS'(CARRY_IN))));
  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && $stable(op_a) && $stable(op_b)) |=> (!start || (done && $stable(sum) && $stable(carry_out))));
endmodule

// File: tb/test_dr_selftimed_adder.sv
module test_dr_selftimed_adder;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum;
  logic carry_out, done;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dr_selftimed_adder #(.WIDTH(W), .CARRY_IN(1'b0)) i_dr_selftimed_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .sum(sum), .carry_out(carry_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int longest_prop(input logic [W-1:0] a, input logic [W-1:0] b);
    int run = 0, best = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] ^ b[i]) begin run++; if (run > best) best = run; end
      else run = 0;
    end
    return best;
  endfunction

  // One operation: R4 R5 R6 R7 R8 R9 R10
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b);
    int lat = 0;
    int exp_lat;
    logic [W:0] exp_sum;
    logic [W-1:0] held_sum;
    logic held_cout;
    exp_lat = 1 + longest_prop(a, b);
    exp_sum = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    #1 check(done == 1'b0, "R7 done before first edge", done, 0);
    while (lat < 40) begin
      @(posedge clk); #1; lat++;
      if (done) break;
    end
    check(lat == exp_lat, "R7 latency R4 R5 R6", lat, exp_lat);
    check({carry_out, sum} == exp_sum, "R8 R1 sum", {carry_out, sum}, exp_sum);
    held_sum = sum; held_cout = carry_out;
    repeat (2) @(posedge clk);
    #1 check(done && sum == held_sum && carry_out == held_cout, "R10 hold", {done, carry_out, sum}, {1'b1, held_cout, held_sum});
    @(negedge clk); start = 1'b0;
    #1 check(done == 1'b0, "R9 done low", done, 0);
    @(posedge clk); #1;
    check(done == 1'b0, "R2 emptied", done, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 check(done == 1'b0, "R2 reset done", done, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check(done == 1'b0, "R2 idle after reset", done, 0);
  endtask

  task automatic t_corners;
    run_add(16'h0000, 16'h0000);  // all kill: R4
    run_add(16'hFFFF, 16'hFFFF);  // all generate: R5
    run_add(16'hFFFF, 16'h0000);  // run of 16 from bit 0: R6
    run_add(16'hFFFF, 16'h0001);  // generate then run of 15
    run_add(16'h00FF, 16'h0F00);  // run of 12 from bit 0
    run_add(16'h8000, 16'h8000);  // carry out only
  endtask

  task automatic t_random;
    logic [31:0] lfsr = 32'hACE1_1234;
    for (int k = 0; k < 20; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 3 == 0) run_add(lfsr[15:0], ~lfsr[15:0] ^ lfsr[31:16] & 16'h1010);
      else            run_add(lfsr[15:0], lfsr[31:16]);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule